// File: doc/BRIEF.md
# Masked Status Write Merge Unit

This unit commits, in a single clock, the register updates that one instruction or one instruction pair has queued during execution. Each 32-bit queue slot names a target (status word, backup status, debug status or live stack pointer) and carries a bit mask and a value. Only the masked bits of the target change. Slots are merged in slot order. Where two status-word writes touch the same condition flags, the earlier write is trimmed, so the later (integer-side) update prevails. A second queue carries whole 64-bit accumulator writes, which are applied after the 32-bit ones.

After the merge, the unit can enter a trap. An ordinary trap saves the status word to the backup register and keeps only the debug-enable and supervisor bits. A debug trap saves it to the debug status register and leaves only the debug-state bit set. Whenever the status word was written or a trap was taken, the supervisor bit selects one of two stack-pointer banks. On a bank change the live pointer is parked in the old bank and reloaded from the new one. The queue is presented on the input ports together with a commit strobe, and nothing is held between commits except the architectural registers.

Top module: `stw_commit_unit`

## Requirements
- R1: A committed 32-bit write changes only the target bits whose mask bit is 1. The targets are coded on `w32_sel_i`: 0 = status, 1 = backup status, 2 = debug status, 3 = live stack pointer.
- R2: Valid slots are applied from slot 0 upward, so a later slot wins on common bits. Slots whose valid bit is 0 have no effect.
- R3: Status bit positions are C=0, VA=1, V=2, S=3, F0..F3=4..7, DS=12, DB=13, SM=15, and the flag set is bits 7..0. When a valid status write shares flag bits with a later valid status write in the same commit, those shared bits are dropped from the earlier write's mask.
- R4: If such a later overlapping status write has V in its mask, the earlier write's VA bit is also dropped, even when the later mask lacks VA.
- R5: When `sys_move_i` is 1, the trimming of R3 and R4 is not applied.
- R6: On trap code 1 (ordinary), the status value after the merge is copied to the backup status register, and the status word keeps only bits DB and SM.
- R7: On trap code 2 (debug), the status value after the merge is copied to the debug status register, and the status word becomes exactly DS. Code 0 and code 3 take no trap.
- R8: When a commit wrote the status word or took a trap, and the resulting SM bit names the other bank, the merged live SP is saved to the current bank and `sp_o` is loaded from the named bank. Otherwise `sp_o` takes the merged value.
- R9: Accumulator writes replace the whole 64-bit register named by `w64_idx_i`, and a later slot wins on the same index.
- R10: With `commit_i` low, no output changes, whatever the queue holds.
- R11: After reset all outputs are zero and bank 0 is current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| commit_i | input | 1 | Apply the presented queue this cycle |
| w32_vld_i | input | 4 | Valid bit per 32-bit slot |
| w32_sel_i | input | 8 | 2-bit target code per slot |
| w32_mask_i | input | 128 | 32-bit mask per slot |
| w32_data_i | input | 128 | 32-bit value per slot |
| w64_vld_i | input | 2 | Valid bit per accumulator slot |
| w64_idx_i | input | 2 | Accumulator index per slot |
| w64_data_i | input | 128 | 64-bit value per slot |
| trap_kind_i | input | 2 | 0 none, 1 ordinary, 2 debug, 3 none |
| sys_move_i | input | 1 | Memory-side op was a system-register move |
| status_o | output | 32 | Status word |
| backup_o | output | 32 | Backup status |
| debug_o | output | 32 | Debug status |
| sp_o | output | 32 | Active stack pointer |
| acc_o | output | 128 | Accumulators, index 0 in the low half |

## Verification
Plain masked writes to the backup register show that unmasked bits hold and that a later slot beats an earlier one. A sweep of pseudo-random pairs of status writes, with and without the system-move flag, is compared with an arithmetic model. Directed V-only-after-VA pairs separate the VA cancellation from plain bit-wise override. Sequences of SP and SM writes tell a bank swap apart from a plain pointer write, and the two trap codes plus code 3 show which register gets the saved copy.

// File: rtl/stw_pkg.sv
package stw_pkg;
   typedef enum logic [1:0] {
      TGT_STATUS = 2'd0,
      TGT_BACKUP = 2'd1,
      TGT_DEBUG  = 2'd2,
      TGT_SP     = 2'd3
   } tgt_e;

   typedef enum logic [1:0] {
      TRAP_NONE  = 2'd0,
      TRAP_ORD   = 2'd1,
      TRAP_DEBUG = 2'd2,
      TRAP_RSVD  = 2'd3
   } trap_e;

   localparam int unsigned BIT_C  = 0;
   localparam int unsigned BIT_VA = 1;
   localparam int unsigned BIT_V  = 2;
   localparam int unsigned BIT_DS = 12;
   localparam int unsigned BIT_DB = 13;
   localparam int unsigned BIT_SM = 15;
   localparam int unsigned FLAG_LO = 0;
   localparam int unsigned FLAG_HI = 7;
   localparam int unsigned NUM_TGT = 4;
   localparam int unsigned MIN_W   = 16;
endpackage

// File: rtl/stw_flag_arbiter.sv
module stw_flag_arbiter
   import stw_pkg::*;
#(
   parameter int unsigned SLOTS  = 4,
   parameter int unsigned DATA_W = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [SLOTS-1:0]             vld_i,
   input  logic [SLOTS-1:0][1:0]        sel_i,
   input  logic [SLOTS-1:0][DATA_W-1:0] mask_i,
   input  logic                         sys_move_i,
   output logic [SLOTS-1:0][DATA_W-1:0] mask_o
);
   localparam logic [DATA_W-1:0] FLAGS =
      DATA_W'(((1 << (FLAG_HI - FLAG_LO + 1)) - 1) << FLAG_LO);
   localparam logic [DATA_W-1:0] VA_BIT = DATA_W'(1) << BIT_VA;
   localparam logic [DATA_W-1:0] V_BIT  = DATA_W'(1) << BIT_V;

   logic [SLOTS-1:0] is_stat;
   always_comb begin
      for (int k = 0; k < SLOTS; k++)
         is_stat[k] = vld_i[k] && (sel_i[k] == TGT_STATUS);
   end

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      logic [DATA_W-1:0] eff;
      logic [DATA_W-1:0] shared;
      always_comb begin
         eff    = mask_i[i];
         shared = '0;
         if (is_stat[i] && !sys_move_i) begin
            for (int j = 0; j < SLOTS; j++) begin
               if (j > i && is_stat[j]) begin
                  shared = mask_i[i] & mask_i[j] & FLAGS;
                  if (shared != '0) begin
                     eff = eff & ~shared;
                     if ((mask_i[j] & V_BIT) != '0)
                        eff = eff & ~VA_BIT;
                  end
               end
            end
         end
         mask_o[i] = eff;
      end

      assert_sysmove_passthru_R5 : assert property (@(posedge clk) disable iff (!rst_n)
         sys_move_i |-> (mask_o[i] == mask_i[i]));
      assert_trim_subset_R3 : assert property (@(posedge clk) disable iff (!rst_n)
         ((mask_o[i] & ~mask_i[i]) == '0));
   end
endmodule

// File: rtl/stw_merge_chain.sv
module stw_merge_chain
   import stw_pkg::*;
#(
   parameter int unsigned SLOTS  = 4,
   parameter int unsigned DATA_W = 32
) (
   input  logic [NUM_TGT-1:0][DATA_W-1:0] cur_i,
   input  logic [SLOTS-1:0]               vld_i,
   input  logic [SLOTS-1:0][1:0]          sel_i,
   input  logic [SLOTS-1:0][DATA_W-1:0]   mask_i,
   input  logic [SLOTS-1:0][DATA_W-1:0]   data_i,
   output logic [NUM_TGT-1:0][DATA_W-1:0] nxt_o
);
   always_comb begin
      nxt_o = cur_i;
      for (int i = 0; i < SLOTS; i++) begin
         if (vld_i[i])
            nxt_o[sel_i[i]] = (nxt_o[sel_i[i]] & ~mask_i[i]) | (data_i[i] & mask_i[i]);
      end
   end
endmodule

// File: rtl/stw_trap_stage.sv
module stw_trap_stage
   import stw_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] stat_i,
   input  logic [DATA_W-1:0] bkp_i,
   input  logic [DATA_W-1:0] dbg_i,
   input  logic [1:0]        kind_i,
   output logic [DATA_W-1:0] stat_o,
   output logic [DATA_W-1:0] bkp_o,
   output logic [DATA_W-1:0] dbg_o,
   output logic              taken_o
);
   localparam logic [DATA_W-1:0] ORD_KEEP = (DATA_W'(1) << BIT_DB) | (DATA_W'(1) << BIT_SM);
   localparam logic [DATA_W-1:0] DS_ONLY  = DATA_W'(1) << BIT_DS;

   always_comb begin
      stat_o  = stat_i;
      bkp_o   = bkp_i;
      dbg_o   = dbg_i;
      taken_o = 1'b0;
      unique case (trap_e'(kind_i))
         TRAP_ORD: begin
            bkp_o   = stat_i;
            stat_o  = stat_i & ORD_KEEP;
            taken_o = 1'b1;
         end
         TRAP_DEBUG: begin
            dbg_o   = stat_i;
            stat_o  = DS_ONLY;
            taken_o = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/stw_commit_unit.sv
module stw_commit_unit
   import stw_pkg::*;
#(
   parameter int unsigned W32_SLOTS = 4,
   parameter int unsigned W64_SLOTS = 2,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ACC_W     = 64,
   parameter int unsigned NUM_ACC   = 2,
   localparam int unsigned ACC_IW   = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1,
   localparam int unsigned NUM_BANK = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         commit_i,
   input  logic [W32_SLOTS-1:0]         w32_vld_i,
   input  logic [W32_SLOTS*2-1:0]       w32_sel_i,
   input  logic [W32_SLOTS*DATA_W-1:0]  w32_mask_i,
   input  logic [W32_SLOTS*DATA_W-1:0]  w32_data_i,
   input  logic [W64_SLOTS-1:0]         w64_vld_i,
   input  logic [W64_SLOTS*ACC_IW-1:0]  w64_idx_i,
   input  logic [W64_SLOTS*ACC_W-1:0]   w64_data_i,
   input  logic [1:0]                   trap_kind_i,
   input  logic                         sys_move_i,
   output logic [DATA_W-1:0]            status_o,
   output logic [DATA_W-1:0]            backup_o,
   output logic [DATA_W-1:0]            debug_o,
   output logic [DATA_W-1:0]            sp_o,
   output logic [NUM_ACC*ACC_W-1:0]     acc_o
);
   if (DATA_W < MIN_W) begin : g_bad_width
      $error("stw_commit_unit: DATA_W must hold the status bit positions");
   end
   if (W32_SLOTS < 1 || W64_SLOTS < 1) begin : g_bad_slots
      $error("stw_commit_unit: both queues need at least one slot");
   end
   if (NUM_ACC < 2) begin : g_bad_acc
      $error("stw_commit_unit: NUM_ACC must be at least 2");
   end

   logic [W32_SLOTS-1:0][1:0]        sel;
   logic [W32_SLOTS-1:0][DATA_W-1:0] raw_mask, data, eff_mask;
   logic [W64_SLOTS-1:0][ACC_IW-1:0] aidx;
   logic [W64_SLOTS-1:0][ACC_W-1:0]  adata;
   assign sel      = w32_sel_i;
   assign raw_mask = w32_mask_i;
   assign data     = w32_data_i;
   assign aidx     = w64_idx_i;
   assign adata    = w64_data_i;

   logic [DATA_W-1:0] status_q, bkp_q, dbg_q, sp_q;
   logic [NUM_BANK-1:0][DATA_W-1:0] bank_q;
   logic cur_q;
   logic [NUM_ACC-1:0][ACC_W-1:0] acc_q;

   stw_flag_arbiter #(.SLOTS(W32_SLOTS), .DATA_W(DATA_W)) arb_i (
      .clk(clk), .rst_n(rst_n), .vld_i(w32_vld_i), .sel_i(sel),
      .mask_i(raw_mask), .sys_move_i(sys_move_i), .mask_o(eff_mask));

   logic [NUM_TGT-1:0][DATA_W-1:0] cur_regs, merged;
   always_comb begin
      cur_regs[TGT_STATUS] = status_q;
      cur_regs[TGT_BACKUP] = bkp_q;
      cur_regs[TGT_DEBUG]  = dbg_q;
      cur_regs[TGT_SP]     = sp_q;
   end

   stw_merge_chain #(.SLOTS(W32_SLOTS), .DATA_W(DATA_W)) mrg_i (
      .cur_i(cur_regs), .vld_i(w32_vld_i), .sel_i(sel),
      .mask_i(eff_mask), .data_i(data), .nxt_o(merged));

   logic [DATA_W-1:0] stat_t, bkp_t, dbg_t;
   logic              trap_taken;
   stw_trap_stage #(.DATA_W(DATA_W)) trap_i (
      .stat_i(merged[TGT_STATUS]), .bkp_i(merged[TGT_BACKUP]),
      .dbg_i(merged[TGT_DEBUG]), .kind_i(trap_kind_i),
      .stat_o(stat_t), .bkp_o(bkp_t), .dbg_o(dbg_t), .taken_o(trap_taken));

   logic stat_written, did_status, new_bank;
   always_comb begin
      stat_written = 1'b0;
      for (int i = 0; i < W32_SLOTS; i++)
         if (w32_vld_i[i] && sel[i] == TGT_STATUS) stat_written = 1'b1;
      did_status = stat_written || trap_taken;
      new_bank   = stat_t[BIT_SM];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         bkp_q    <= '0;
         dbg_q    <= '0;
         sp_q     <= '0;
         bank_q   <= '0;
         cur_q    <= 1'b0;
         acc_q    <= '0;
      end else if (commit_i) begin
         status_q <= stat_t;
         bkp_q    <= bkp_t;
         dbg_q    <= dbg_t;
         if (did_status && new_bank != cur_q) begin
            bank_q[cur_q] <= merged[TGT_SP];
            cur_q         <= new_bank;
            sp_q          <= bank_q[new_bank];
         end else begin
            sp_q <= merged[TGT_SP];
         end
         for (int j = 0; j < W64_SLOTS; j++)
            if (w64_vld_i[j] && (int'(aidx[j]) < NUM_ACC))
               acc_q[aidx[j]] <= adata[j];
      end
   end

   assign status_o = status_q;
   assign backup_o = bkp_q;
   assign debug_o  = dbg_q;
   assign sp_o     = sp_q;
   assign acc_o    = acc_q;

   assert_idle_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> ($stable(status_q) && $stable(bkp_q) && $stable(dbg_q)
                     && $stable(sp_q) && $stable(acc_q)));
   assert_ord_trap_clear_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && trap_kind_i == TRAP_ORD)
      |=> ((status_q & ~((DATA_W'(1) << BIT_DB) | (DATA_W'(1) << BIT_SM))) == '0));
   assert_dbg_trap_value_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && trap_kind_i == TRAP_DEBUG) |=> (status_q == (DATA_W'(1) << BIT_DS)));
   assert_bank_follows_sm_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && did_status) |=> (cur_q == status_q[BIT_SM]));
endmodule

// File: tb/stw_commit_unit_tb_top.sv
module stw_commit_unit_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic         commit_i;
   logic [3:0]   w32_vld_i;
   logic [7:0]   w32_sel_i;
   logic [127:0] w32_mask_i, w32_data_i;
   logic [1:0]   w64_vld_i, w64_idx_i;
   logic [127:0] w64_data_i;
   logic [1:0]   trap_kind_i;
   logic         sys_move_i;
   logic [31:0]  status_o, backup_o, debug_o, sp_o;
   logic [127:0] acc_o;

   stw_commit_unit dut_i (.*);

   int n_chk = 0, n_fail = 0;
   logic [31:0] seed = 32'h1234_5678;

   localparam logic [31:0] VA = 32'h2, V = 32'h4, FL = 32'hFF;
   localparam logic [31:0] DS = 32'h1000, DB = 32'h2000, SM = 32'h8000;

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clr();
      w32_vld_i = '0; w32_sel_i = '0; w32_mask_i = '0; w32_data_i = '0;
      w64_vld_i = '0; w64_idx_i = '0; w64_data_i = '0;
      trap_kind_i = 2'd0; sys_move_i = 1'b0;
   endtask

   task automatic put(int s, logic [1:0] tgt, logic [31:0] m, logic [31:0] d);
      w32_vld_i[s] = 1'b1;
      w32_sel_i[s*2 +: 2] = tgt;
      w32_mask_i[s*32 +: 32] = m;
      w32_data_i[s*32 +: 32] = d;
   endtask

   task automatic fire(logic c);
      commit_i = c;
      @(negedge clk);
      commit_i = 1'b0;
      clr();
      #1;
   endtask

   function automatic logic [31:0] nxt_rand();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed;
   endfunction

   initial begin
      #40000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      commit_i = 1'b0;
      clr();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 status", status_o, 0); chk("R11 backup", backup_o, 0);
      chk("R11 debug", debug_o, 0);   chk("R11 sp", sp_o, 0);
      chk("R11 acc", acc_o[63:0], 0);

      // R1 masked writes to backup
      put(0, 2'd1, 32'h0000_FFFF, 32'hAAAA_5555); fire(1);
      chk("R1 low half", backup_o, 32'h0000_5555);
      put(0, 2'd1, 32'hFF00_0000, 32'h1234_5678); fire(1);
      chk("R1 top byte", backup_o, 32'h1200_5555);

      // R2 order and invalid slot
      put(0, 2'd2, 32'hFFFF_FFFF, 32'h1111_1111);
      put(2, 2'd2, 32'h0000_FFFF, 32'h2222_2222);
      w32_sel_i[3*2 +: 2] = 2'd2; w32_mask_i[127:96] = '1; w32_data_i[127:96] = 32'hDEAD_BEEF;
      fire(1);
      chk("R2 later slot wins, invalid ignored", debug_o, 32'h1111_2222);

      // R10 no commit
      put(0, 2'd1, '1, 32'hCAFE_F00D); w64_vld_i = 2'b01; w64_data_i[63:0] = 64'h77;
      trap_kind_i = 2'd1; fire(0);
      chk("R10 backup held", backup_o, 32'h1200_5555);
      chk("R10 acc held", acc_o[63:0], 0);
      chk("R10 status held", status_o, 0);

      // R3 directed: shared flag F0, earlier F1 kept
      put(0, 2'd0, 32'h30, 32'h30); put(1, 2'd0, 32'h10, 32'h00); fire(1);
      chk("R3 shared flag trimmed", status_o & FL, 32'h20);

      // R4 VA dropped when later write carries V
      put(0, 2'd0, FL, 32'h0); fire(1);
      put(0, 2'd0, VA | V, VA | V); put(1, 2'd0, V, 32'h0); fire(1);
      chk("R4 VA suppressed", status_o & FL, 32'h0);
      // R5 system move keeps earlier VA
      put(0, 2'd0, VA | V, VA | V); put(1, 2'd0, V, 32'h0); sys_move_i = 1'b1; fire(1);
      chk("R5 VA kept under system move", status_o & FL, VA);

      // R3/R4/R5 sweep against arithmetic model
      for (int it = 0; it < 96; it++) begin
         logic [31:0] m0, m1, d0, d1, s, e0;
         logic sm;
         m0 = nxt_rand() & 32'h7FFF; m1 = nxt_rand() & 32'h7FFF;
         d0 = nxt_rand(); d1 = nxt_rand();
         sm = it[0];
         s = status_o;
         e0 = m0;
         if (!sm && ((m0 & m1 & FL) != 0)) begin
            e0 = m0 & ~(m0 & m1 & FL);
            if ((m1 & V) != 0) e0 = e0 & ~VA;
         end
         s = (s & ~e0) | (d0 & e0);
         s = (s & ~m1) | (d1 & m1);
         put(1, 2'd0, m0, d0); put(3, 2'd0, m1, d1); sys_move_i = sm;
         fire(1);
         chk(sm ? "R5 sweep" : "R3 R4 sweep", status_o, s);
      end

      // R8 stack banks
      put(0, 2'd0, '1, 32'h0); fire(1);
      put(0, 2'd3, '1, 32'h100); fire(1);
      chk("R8 plain sp write", sp_o, 32'h100);
      put(0, 2'd0, SM, SM); fire(1);
      chk("R8 switch to bank1", sp_o, 32'h0);
      put(0, 2'd3, '1, 32'h200); fire(1);
      put(0, 2'd0, SM, 32'h0); fire(1);
      chk("R8 back to bank0", sp_o, 32'h100);
      put(0, 2'd0, SM, SM); fire(1);
      chk("R8 bank1 restored", sp_o, 32'h200);
      put(0, 2'd0, 32'h1, 32'h1); fire(1);
      chk("R8 same bank no swap", sp_o, 32'h200);

      // R6 ordinary trap
      put(0, 2'd0, 32'hFFFF, 32'hF0F3 | SM | DB); trap_kind_i = 2'd1; fire(1);
      chk("R6 backup saved", backup_o, 32'hF0F3 | SM | DB);
      chk("R6 status kept DB SM", status_o, SM | DB);
      chk("R6 sp bank unchanged", sp_o, 32'h200);

      // R7 debug trap and code 3
      put(0, 2'd0, 32'hFF, 32'h5A); trap_kind_i = 2'd2; fire(1);
      chk("R7 debug saved", debug_o, SM | DB | 32'h5A);
      chk("R7 status is DS", status_o, DS);
      chk("R8 debug trap swaps to bank0", sp_o, 32'h100);
      put(0, 2'd0, 32'hFF, 32'h11); trap_kind_i = 2'd3; fire(1);
      chk("R7 code3 no trap status", status_o, DS | 32'h11);
      chk("R7 code3 debug held", debug_o, SM | DB | 32'h5A);

      // R9 accumulators
      w64_vld_i = 2'b11; w64_idx_i = 2'b11;
      w64_data_i = {64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444}; fire(1);
      chk("R9 later slot wins", acc_o[127:64], 64'hAAAA_BBBB_CCCC_DDDD);
      chk("R9 other acc untouched", acc_o[63:0], 64'h0);
      w64_vld_i = 2'b01; w64_idx_i = 2'b00; w64_data_i[63:0] = 64'h0123_4567_89AB_CDEF; fire(1);
      chk("R9 whole write", acc_o[63:0], 64'h0123_4567_89AB_CDEF);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule